// File: doc/BRIEF.md
# ECC Error Logging Register Block

This block sits beside a SECDED-protected memory controller. It takes the error reports of that controller, which are one-cycle pulses that mark a corrected (single-bit) error or an uncorrectable (multi-bit) error, each with the address of the failing access. It keeps a saturating count for each error class. For uncorrectable errors it captures the address of the first one since the last clear. For corrected errors it captures the address of the latest one. It drives a level-high interrupt line toward the system interrupt controller.

Software reaches the block through a 32-bit register port with word-aligned byte offsets. A read has no wait state and returns the register selected by the address in the same cycle. A write takes effect at the next clock edge. Every register except the key register is write-protected. A fixed magic word written to the key register opens the protection, and the bitwise complement of that word closes it again. The configuration register holds the ECC-enable and memory-type bits that the controller uses.

Top module: `ecc_err_log`

## Requirements
- R1: After reset, every register reads 0, the block is locked and `irq_o` is low.
- R2: Writing 0xFC600309 to offset 0x00 unlocks the block, and offset 0x00 then reads 1. Writing 0x039FFCF6 (the complement) locks it again, and offset 0x00 then reads 0. Any other value written there leaves the lock state unchanged.
- R3: While the block is locked, writes to offsets 0x04 and 0x50 are dropped. Reads of every register are allowed at all times.
- R4: Offset 0x04 holds the ECC enable at bit 7 and the memory type at bit 4 (1 = DDR4, 0 = DDR3). Its other bits read 0. `ecc_en_o` and `ddr4_o` follow bits 7 and 4.
- R5: The corrected-error count at offset 0x50 bits 23:16 goes up by one for each corrected event and stays at 255 once it reaches 255.
- R6: The uncorrectable-error count at offset 0x50 bits 15:12 goes up by one for each uncorrectable event and stays at 15 once it reaches 15.
- R7: Offset 0x58 captures the address of the first uncorrectable event after reset or after a clear. Later uncorrectable events leave it unchanged.
- R8: Offset 0x5C is overwritten by every corrected event and so holds the address of the most recent one.
- R9: Error events have no effect while the ECC enable bit is 0.
- R10: `irq_o` is high exactly when (bit 0 of offset 0x50 is set and the corrected count is nonzero) or (bit 1 is set and the uncorrectable count is nonzero). Bits 1:0 read back as written.
- R11: Writing 1 to bit 31 of offset 0x50 zeroes both counts at that edge, which drops `irq_o`. The counts stay at zero and any events in those cycles are dropped until 0 is written to bit 31. The uncorrectable address is re-armed, so the next uncorrectable event captures its address. Bit 31 reads back as written.
- R12: Writes to offsets 0x58, 0x5C and to unmapped offsets are ignored, and unmapped offsets read 0.
- R13: A corrected event and an uncorrectable event that arrive in the same cycle are both counted and both logged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| bus_we_i | input | 1 | Write strobe for one cycle |
| bus_addr_i | input | BUS_AW | Byte offset of the register |
| bus_wdata_i | input | 32 | Write data |
| bus_rdata_o | output | 32 | Read data for `bus_addr_i`, combinational |
| ce_evt_i | input | 1 | Corrected-error pulse |
| ce_addr_i | input | ERR_AW | Address of the corrected access |
| ue_evt_i | input | 1 | Uncorrectable-error pulse |
| ue_addr_i | input | ERR_AW | Address of the uncorrectable access |
| ecc_en_o | output | 1 | ECC enable from the configuration register |
| ddr4_o | output | 1 | Memory type from the configuration register, 1 = DDR4 |
| irq_o | output | 1 | Level-high interrupt |

## Verification
Every state change in this block appears one rising edge after the input that caused it: a register write, an error pulse or a clear. Read data and `irq_o` follow that state with no further register stage. The bench therefore drives each stimulus just after a rising edge and holds it for exactly one cycle. It then reads back through the combinational read port one time step after the next edge, so each result is sampled in the cycle it becomes due. The counter sweeps go past both saturation points one event at a time, and the expected count and logged address are computed from the event number after every pulse.

// File: rtl/ecc_log_pkg.sv
package ecc_log_pkg;
  localparam logic [31:0] UNLOCK_KEY = 32'hFC60_0309;

  localparam int OFF_KEY  = 'h00;
  localparam int OFF_CFG  = 'h04;
  localparam int OFF_ICTL = 'h50;
  localparam int OFF_UEA  = 'h58;
  localparam int OFF_CEA  = 'h5C;

  localparam int CFG_ECC_BIT  = 7;
  localparam int CFG_DDR4_BIT = 4;

  localparam int CE_CNT_W  = 8;
  localparam int CE_CNT_LO = 16;
  localparam int UE_CNT_W  = 4;
  localparam int UE_CNT_LO = 12;
  localparam int CLR_BIT   = 31;
  localparam int IEN_W     = 2;
endpackage

// File: rtl/ecc_key_guard.sv
module ecc_key_guard #(
  parameter logic [31:0] KEY = 32'hFC60_0309
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        wr_i,
  input  logic [31:0] wdata_i,
  output logic        unlocked_o
);
  logic unlocked_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                          unlocked_q <= 1'b0;
    else if (wr_i && wdata_i == KEY)      unlocked_q <= 1'b1;
    else if (wr_i && wdata_i == ~KEY)     unlocked_q <= 1'b0;
  end

  assign unlocked_o = unlocked_q;

  assert_key_open_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_i && wdata_i == KEY) |=> unlocked_o);
  assert_key_close_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_i && wdata_i == ~KEY) |=> !unlocked_o);
  assert_key_other_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_i && wdata_i != KEY && wdata_i != ~KEY) |=> $stable(unlocked_o));
endmodule

// File: rtl/ecc_err_track.sv
module ecc_err_track #(
  parameter int CNT_W      = 8,
  parameter int ADDR_W     = 32,
  parameter bit KEEP_FIRST = 1'b0
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              en_i,
  input  logic              clr_i,
  input  logic              evt_i,
  input  logic [ADDR_W-1:0] addr_i,
  output logic [CNT_W-1:0]  cnt_o,
  output logic [ADDR_W-1:0] addr_o
);
  localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

  logic [CNT_W-1:0]  cnt_q;
  logic [ADDR_W-1:0] addr_q;
  logic              take, capture;

  // clear outranks a coincident event
  assign take = evt_i && en_i && !clr_i;

  generate
    if (KEEP_FIRST) begin : g_first
      assign capture = take && (cnt_q == '0);
    end else begin : g_last
      assign capture = take;
    end
  endgenerate

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                         cnt_q <= '0;
    else if (clr_i)                      cnt_q <= '0;
    else if (take && cnt_q != CNT_MAX)   cnt_q <= cnt_q + 1'b1;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      addr_q <= '0;
    else if (capture) addr_q <= addr_i;
  end

  assign cnt_o  = cnt_q;
  assign addr_o = addr_q;

  assert_cnt_sat_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cnt_q == CNT_MAX && !clr_i) |=> cnt_q == CNT_MAX);
  assert_cnt_clr_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_i |=> cnt_q == '0);
  assert_evt_off_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!en_i && !clr_i) |=> $stable(cnt_q) && $stable(addr_q));
  assert_cnt_step_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (take && cnt_q != CNT_MAX) |=> cnt_q == $past(cnt_q) + 1'b1);

  generate
    if (KEEP_FIRST) begin : g_chk_first
      assert_first_kept_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (cnt_q != '0 && !clr_i) |=> $stable(addr_q));
    end else begin : g_chk_last
      assert_last_taken_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
        take |=> addr_q == $past(addr_i));
    end
  endgenerate
endmodule

// File: rtl/ecc_err_log.sv
module ecc_err_log
  import ecc_log_pkg::*;
#(
  parameter int BUS_AW = 8,
  parameter int ERR_AW = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              bus_we_i,
  input  logic [BUS_AW-1:0] bus_addr_i,
  input  logic [31:0]       bus_wdata_i,
  output logic [31:0]       bus_rdata_o,
  input  logic              ce_evt_i,
  input  logic [ERR_AW-1:0] ce_addr_i,
  input  logic              ue_evt_i,
  input  logic [ERR_AW-1:0] ue_addr_i,
  output logic              ecc_en_o,
  output logic              ddr4_o,
  output logic              irq_o
);
  localparam logic [BUS_AW-1:0] A_KEY  = BUS_AW'(OFF_KEY);
  localparam logic [BUS_AW-1:0] A_CFG  = BUS_AW'(OFF_CFG);
  localparam logic [BUS_AW-1:0] A_ICTL = BUS_AW'(OFF_ICTL);
  localparam logic [BUS_AW-1:0] A_UEA  = BUS_AW'(OFF_UEA);
  localparam logic [BUS_AW-1:0] A_CEA  = BUS_AW'(OFF_CEA);

  logic                unlocked;
  logic                wr_key, wr_cfg, wr_ictl;
  logic                ecc_en_q, ddr4_q;
  logic [IEN_W-1:0]    ien_q;
  logic                clr_q, clr_now;
  logic [CE_CNT_W-1:0] ce_cnt;
  logic [UE_CNT_W-1:0] ue_cnt;
  logic [ERR_AW-1:0]   ce_addr, ue_addr;

  assign wr_key  = bus_we_i && bus_addr_i == A_KEY;
  assign wr_cfg  = bus_we_i && unlocked && bus_addr_i == A_CFG;
  assign wr_ictl = bus_we_i && unlocked && bus_addr_i == A_ICTL;

  ecc_key_guard #(.KEY(UNLOCK_KEY)) u_key (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .wr_i       (wr_key),
    .wdata_i    (bus_wdata_i),
    .unlocked_o (unlocked)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ecc_en_q <= 1'b0;
      ddr4_q   <= 1'b0;
    end else if (wr_cfg) begin
      ecc_en_q <= bus_wdata_i[CFG_ECC_BIT];
      ddr4_q   <= bus_wdata_i[CFG_DDR4_BIT];
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ien_q <= '0;
      clr_q <= 1'b0;
    end else if (wr_ictl) begin
      ien_q <= bus_wdata_i[IEN_W-1:0];
      clr_q <= bus_wdata_i[CLR_BIT];
    end
  end

  // clear acts on the writing edge and holds while the bit stays set
  assign clr_now = clr_q || (wr_ictl && bus_wdata_i[CLR_BIT]);

  ecc_err_track #(.CNT_W(CE_CNT_W), .ADDR_W(ERR_AW), .KEEP_FIRST(1'b0)) u_ce (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .en_i   (ecc_en_q),
    .clr_i  (clr_now),
    .evt_i  (ce_evt_i),
    .addr_i (ce_addr_i),
    .cnt_o  (ce_cnt),
    .addr_o (ce_addr)
  );

  ecc_err_track #(.CNT_W(UE_CNT_W), .ADDR_W(ERR_AW), .KEEP_FIRST(1'b1)) u_ue (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .en_i   (ecc_en_q),
    .clr_i  (clr_now),
    .evt_i  (ue_evt_i),
    .addr_i (ue_addr_i),
    .cnt_o  (ue_cnt),
    .addr_o (ue_addr)
  );

  always_comb begin
    bus_rdata_o = '0;
    unique case (bus_addr_i)
      A_KEY:  bus_rdata_o[0] = unlocked;
      A_CFG: begin
        bus_rdata_o[CFG_ECC_BIT]  = ecc_en_q;
        bus_rdata_o[CFG_DDR4_BIT] = ddr4_q;
      end
      A_ICTL: begin
        bus_rdata_o[CLR_BIT]                        = clr_q;
        bus_rdata_o[CE_CNT_LO +: CE_CNT_W]          = ce_cnt;
        bus_rdata_o[UE_CNT_LO +: UE_CNT_W]          = ue_cnt;
        bus_rdata_o[IEN_W-1:0]                      = ien_q;
      end
      A_UEA:  bus_rdata_o = 32'(ue_addr);
      A_CEA:  bus_rdata_o = 32'(ce_addr);
      default: bus_rdata_o = '0;
    endcase
  end

  assign irq_o    = (ien_q[0] && ce_cnt != '0) || (ien_q[1] && ue_cnt != '0);
  assign ecc_en_o = ecc_en_q;
  assign ddr4_o   = ddr4_q;

  assert_locked_cfg_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bus_we_i && !unlocked && bus_addr_i == A_CFG) |=> $stable({ecc_en_q, ddr4_q}));
  assert_locked_ictl_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bus_we_i && !unlocked && bus_addr_i == A_ICTL) |=> $stable({clr_q, ien_q}));
  assert_irq_low_clr_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_q |-> !irq_o);
  assert_both_counted_R13: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ce_evt_i && ue_evt_i && ecc_en_q && !clr_now && ue_cnt == '0) |=> ue_cnt != '0 && ce_cnt != '0);
endmodule

// File: tb/ecc_err_log_tb.sv
module ecc_err_log_tb;
  localparam int BUS_AW = 8;
  localparam int ERR_AW = 32;
  localparam logic [31:0] KEY = 32'hFC60_0309;

  logic              clk_i = 1'b0;
  logic              rst_ni = 1'b0;
  logic              bus_we_i = 1'b0;
  logic [BUS_AW-1:0] bus_addr_i = '0;
  logic [31:0]       bus_wdata_i = '0;
  logic [31:0]       bus_rdata_o;
  logic              ce_evt_i = 1'b0;
  logic [ERR_AW-1:0] ce_addr_i = '0;
  logic              ue_evt_i = 1'b0;
  logic [ERR_AW-1:0] ue_addr_i = '0;
  logic              ecc_en_o, ddr4_o, irq_o;

  int n_chk = 0;
  int n_bad = 0;
  bit done  = 1'b0;

  always #10 clk_i = ~clk_i;

  ecc_err_log #(.BUS_AW(BUS_AW), .ERR_AW(ERR_AW)) u_dut (
    .clk_i(clk_i), .rst_ni(rst_ni),
    .bus_we_i(bus_we_i), .bus_addr_i(bus_addr_i), .bus_wdata_i(bus_wdata_i),
    .bus_rdata_o(bus_rdata_o),
    .ce_evt_i(ce_evt_i), .ce_addr_i(ce_addr_i),
    .ue_evt_i(ue_evt_i), .ue_addr_i(ue_addr_i),
    .ecc_en_o(ecc_en_o), .ddr4_o(ddr4_o), .irq_o(irq_o)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    bus_addr_i = a; bus_wdata_i = d; bus_we_i = 1'b1;
    @(posedge clk_i); #1;
    bus_we_i = 1'b0;
  endtask

  task automatic rd_chk(input string req, input logic [7:0] a, input logic [31:0] exp);
    bus_addr_i = a; #1;
    chk(req, bus_rdata_o, exp);
  endtask

  task automatic evt(input bit ce, input bit ue, input logic [31:0] ca, input logic [31:0] ua);
    ce_evt_i = ce; ue_evt_i = ue; ce_addr_i = ca; ue_addr_i = ua;
    @(posedge clk_i); #1;
    ce_evt_i = 1'b0; ue_evt_i = 1'b0;
  endtask

  function automatic logic [31:0] ictl(bit clr, int ce, int ue, int en);
    return {clr, 7'd0, 8'(ce), 4'(ue), 10'd0, 2'(en)};
  endfunction

  initial begin
    repeat (20000) @(posedge clk_i);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog act=running exp=finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk_i);
    #1 rst_ni = 1'b1;
    @(posedge clk_i); #1;

    // R1 reset state
    rd_chk("R1 key", 8'h00, 0);
    rd_chk("R1 cfg", 8'h04, 0);
    rd_chk("R1 ictl", 8'h50, 0);
    rd_chk("R1 uea", 8'h58, 0);
    rd_chk("R1 cea", 8'h5C, 0);
    chk("R1 irq", {31'd0, irq_o}, 0);

    // R3 locked writes dropped
    wr(8'h04, 32'h0000_0090);
    rd_chk("R3 cfg locked", 8'h04, 0);
    wr(8'h50, 32'h0000_0003);
    rd_chk("R3 ictl locked", 8'h50, 0);

    // R2 key handling
    wr(8'h00, 32'h1234_5678);
    rd_chk("R2 wrong key", 8'h00, 0);
    wr(8'h00, KEY);
    rd_chk("R2 unlock", 8'h00, 1);
    wr(8'h00, 32'hDEAD_BEEF);
    rd_chk("R2 other keeps", 8'h00, 1);

    // R4 config bits
    wr(8'h04, 32'hFFFF_FFFF);
    rd_chk("R4 cfg all", 8'h04, 32'h90);
    chk("R4 ecc_en_o", {31'd0, ecc_en_o}, 1);
    chk("R4 ddr4_o", {31'd0, ddr4_o}, 1);

    // R9 events ignored with ECC off
    wr(8'h04, 32'h0000_0010);
    evt(1, 1, 32'h55, 32'h66);
    rd_chk("R9 ictl off", 8'h50, 0);
    rd_chk("R9 cea off", 8'h5C, 0);
    rd_chk("R9 uea off", 8'h58, 0);

    wr(8'h04, 32'h0000_0080);
    chk("R4 ddr3", {31'd0, ddr4_o}, 0);
    wr(8'h50, 32'h0000_0003);
    rd_chk("R10 ien readback", 8'h50, ictl(0, 0, 0, 3));
    chk("R10 irq idle", {31'd0, irq_o}, 0);

    // R5 R8 corrected sweep past saturation
    for (int n = 1; n <= 260; n++) begin
      evt(1, 0, 32'h1000 + n * 8, 0);
      rd_chk("R5 ce count", 8'h50, ictl(0, (n > 255) ? 255 : n, 0, 3));
      rd_chk("R8 ce last addr", 8'h5C, 32'h1000 + n * 8);
    end
    chk("R10 irq ce", {31'd0, irq_o}, 1);

    // R11 clear
    wr(8'h50, 32'h8000_0003);
    rd_chk("R11 clear zeroes", 8'h50, ictl(1, 0, 0, 3));
    chk("R11 irq drops", {31'd0, irq_o}, 0);
    evt(1, 1, 32'h99, 32'h99);
    rd_chk("R11 held during clear", 8'h50, ictl(1, 0, 0, 3));
    wr(8'h50, 32'h0000_0003);

    // R6 R7 uncorrectable sweep
    for (int n = 1; n <= 20; n++) begin
      evt(0, 1, 0, 32'hA000 + n);
      rd_chk("R6 ue count", 8'h50, ictl(0, 0, (n > 15) ? 15 : n, 3));
      rd_chk("R7 ue first addr", 8'h58, 32'hA001);
    end

    // R10 enable masks
    wr(8'h50, 32'h0000_0001);
    chk("R10 irq ce-only mask", {31'd0, irq_o}, 0);
    wr(8'h50, 32'h0000_0002);
    chk("R10 irq ue mask", {31'd0, irq_o}, 1);
    wr(8'h50, 32'h0000_0000);
    chk("R10 irq masked", {31'd0, irq_o}, 0);

    // R13 simultaneous events, R7 re-arm after clear
    wr(8'h50, 32'h8000_0003);
    wr(8'h50, 32'h0000_0003);
    evt(1, 1, 32'h77, 32'h88);
    rd_chk("R13 both counted", 8'h50, ictl(0, 1, 1, 3));
    rd_chk("R13 R7 ue rearmed", 8'h58, 32'h88);
    rd_chk("R13 ce addr", 8'h5C, 32'h77);

    // R9 again after disabling
    wr(8'h04, 32'h0000_0000);
    evt(1, 0, 32'h44, 0);
    rd_chk("R9 ce ignored", 8'h50, ictl(0, 1, 1, 3));
    rd_chk("R9 ce addr kept", 8'h5C, 32'h77);

    // R12 read-only and unmapped
    wr(8'h5C, 32'hFFFF_FFFF);
    rd_chk("R12 cea ro", 8'h5C, 32'h77);
    wr(8'h58, 32'hFFFF_FFFF);
    rd_chk("R12 uea ro", 8'h58, 32'h88);
    wr(8'h40, 32'hFFFF_FFFF);
    rd_chk("R12 unmapped", 8'h40, 0);

    // R2 relock, R3 writes dropped afterwards
    wr(8'h00, ~KEY);
    rd_chk("R2 relock", 8'h00, 0);
    wr(8'h50, 32'h8000_0000);
    rd_chk("R3 ictl kept", 8'h50, ictl(0, 1, 1, 3));
    wr(8'h04, 32'h0000_0090);
    rd_chk("R3 cfg kept", 8'h04, 0);

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule